// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Unit

The unit watches a bus of already resolved, synchronous pin levels that is split into groups of eight pins. It has three groups by default. Each group has its own eight-bit selection mask. A level change in either direction on any selected pin of a group latches a pending bit for that whole group. The unit does not record which pin moved or which level it reached.

A per-group enable bit decides whether a pending group may request the processor. When several enabled groups are pending, the lowest-numbered group is presented first, together with its vector number. When the processor acknowledges, that group's pending bit is cleared. The request is then held low for the two cycles of vector entry. Software can also drop pending bits by writing ones to the clear address.

Top module: `pcint_unit`

## Requirements
- R1: While reset is asserted and right after it, every pending bit (`grpFlags`) is 0 and `irq` is 0.
- R2: A low-to-high change on a pin whose mask bit is 1 sets pending bit g of `grpFlags` for its group g (pins g*8 to g*8+7) one clock after the change is sampled.
- R3: A high-to-low change on a masked pin sets its group's pending bit in the same way as a rising change.
- R4: A change on a pin whose mask bit is 0 sets no pending bit. A pin that is already high when its mask bit is written to 1 sets nothing. Its next falling change does set the bit.
- R5: Writing data to address NUM_GROUPS+1 (4 by default) clears each pending bit whose data bit is 1 and leaves the others alone. Addresses 0..NUM_GROUPS-1 write group masks, and address NUM_GROUPS (3) writes the enable bits, bit g for group g.
- R6: A pending bit is recorded whether or not its group is enabled. `irq` is 1 only when at least one pending group has its enable bit at 1.
- R7: With `irq` at 1, `vector` equals 6 + 2*g for the lowest-numbered pending enabled group g: 6, 8 or 10.
- R8: An `intAck` pulse while `irq` is 1 clears only the presented group's pending bit. `irq` then stays 0 for the next 2 cycles (vector entry) before another group may be presented.
- R9: An `intAck` pulse while `irq` is 0 changes no pending bit.
- R10: When a masked change and a software clear of the same group fall in the same cycle, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinBus | input | 24 | Resolved pin levels; group g owns bits g*8+7..g*8 |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address: masks 0..2, enable 3, clear 4 |
| wrData | input | 8 | Write data |
| intAck | input | 1 | Processor acknowledge of the presented request |
| irq | output | 1 | Interrupt request |
| vector | output | 8 | Vector number of the presented group |
| grpFlags | output | 3 | Pending bit per group, bit g for group g |

## Verification
A table of pin patterns is applied with mask patterns that differ per group. The patterns include single rising and falling changes on masked pins, changes on unmasked pins only, and mixed steps where one group sees both a masked and an unmasked change. These cases separate a per-pin mask decode from a whole-group trigger, and an any-edge detector from a rising-only or falling-only one. Directed cases then cover a pin that is high before its mask is set, a partial software clear, a pending group whose enable is off, priority among three pending groups stepped through by acknowledges, an acknowledge with no request, and a clear that meets a new change in the same cycle.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  // Index width for group numbers carried in the strobe struct (up to 16 groups).
  localparam int GRP_IDX_W = 4;

  typedef struct packed {
    logic                 ackFire;   // acknowledge accepted this cycle
    logic [GRP_IDX_W-1:0] ackGroup;  // group whose pending bit is dropped
  } pcint_strobe_t;
endpackage

// File: rtl/pcint_datapath.sv
module pcint_datapath
  import pcint_pkg::*;
#(
  parameter int NUM_GROUPS = 3,
  parameter int GRP_PINS   = 8,
  parameter int ADDR_W     = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_GROUPS*GRP_PINS-1:0] pinBus,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [GRP_PINS-1:0]            wrData,
  input  pcint_strobe_t                  strobe,
  output logic [NUM_GROUPS-1:0]          flags,
  output logic [NUM_GROUPS-1:0]          enables
);
  localparam logic [ADDR_W-1:0] ENABLE_ADDR = ADDR_W'(NUM_GROUPS);
  localparam logic [ADDR_W-1:0] CLEAR_ADDR  = ADDR_W'(NUM_GROUPS + 1);

  logic enWrite;
  logic clrWrite;
  assign enWrite  = wrEn && (wrAddr == ENABLE_ADDR);
  assign clrWrite = wrEn && (wrAddr == CLEAR_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enables <= '0;
    end else if (enWrite) begin
      enables <= wrData[NUM_GROUPS-1:0];
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    logic [GRP_PINS-1:0] curPins;
    logic [GRP_PINS-1:0] prevPins;
    logic [GRP_PINS-1:0] maskReg;
    logic                edgeHit;
    logic                dropFlag;

    assign curPins = pinBus[g*GRP_PINS +: GRP_PINS];

    // Previous-cycle copy of every pin, tracked regardless of the mask.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevPins <= '0;
      end else begin
        prevPins <= curPins;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskReg <= '0;
      end else if (wrEn && (wrAddr == ADDR_W'(g))) begin
        maskReg <= wrData;
      end
    end

    assign edgeHit  = |((curPins ^ prevPins) & maskReg);
    assign dropFlag = (clrWrite && wrData[g]) ||
                      (strobe.ackFire && (strobe.ackGroup == GRP_IDX_W'(g)));

    // A new change wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flags[g] <= 1'b0;
      end else begin
        flags[g] <= edgeHit | (flags[g] & ~dropFlag);
      end
    end
  end
endmodule

// File: rtl/pcint_control.sv
module pcint_control
  import pcint_pkg::*;
#(
  parameter int NUM_GROUPS  = 3,
  parameter int VEC_W       = 8,
  parameter int VEC_BASE    = 6,
  parameter int VEC_STEP    = 2,
  parameter int ENTRY_CYC   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_GROUPS-1:0] flags,
  input  logic [NUM_GROUPS-1:0] enables,
  input  logic                  intAck,
  output logic                  irq,
  output logic [VEC_W-1:0]      vector,
  output pcint_strobe_t         strobe
);
  localparam int CNT_W = $clog2(ENTRY_CYC + 1);

  logic [NUM_GROUPS-1:0] pending;
  logic [GRP_IDX_W-1:0]  selGroup;
  logic                  anyPending;
  logic [CNT_W-1:0]      entryCnt;
  logic                  inEntry;

  assign pending    = flags & enables;
  assign anyPending = |pending;

  // Lowest-numbered pending group has priority.
  always_comb begin
    selGroup = '0;
    for (int i = NUM_GROUPS - 1; i >= 0; i--) begin
      if (pending[i]) selGroup = GRP_IDX_W'(i);
    end
  end

  assign inEntry = (entryCnt != '0);
  assign irq     = anyPending && !inEntry;
  assign vector  = VEC_W'(VEC_BASE) + VEC_W'(selGroup) * VEC_W'(VEC_STEP);

  assign strobe.ackFire  = intAck && irq;
  assign strobe.ackGroup = selGroup;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryCnt <= '0;
    end else if (strobe.ackFire) begin
      entryCnt <= CNT_W'(ENTRY_CYC);
    end else if (inEntry) begin
      entryCnt <= entryCnt - 1'b1;
    end
  end
endmodule

// File: rtl/pcint_unit.sv
module pcint_unit
  import pcint_pkg::*;
#(
  parameter int NUM_GROUPS = 3,
  parameter int GRP_PINS   = 8,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 6,
  parameter int VEC_STEP   = 2,
  parameter int ENTRY_CYC  = 2,
  localparam int ADDR_W    = $clog2(NUM_GROUPS + 2),
  localparam int BUS_W     = NUM_GROUPS * GRP_PINS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BUS_W-1:0]      pinBus,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [GRP_PINS-1:0]   wrData,
  input  logic                  intAck,
  output logic                  irq,
  output logic [VEC_W-1:0]      vector,
  output logic [NUM_GROUPS-1:0] grpFlags
);
  pcint_strobe_t         strobe;
  logic [NUM_GROUPS-1:0] enReg;

  pcint_datapath #(
    .NUM_GROUPS(NUM_GROUPS),
    .GRP_PINS  (GRP_PINS),
    .ADDR_W    (ADDR_W)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .pinBus (pinBus),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .strobe (strobe),
    .flags  (grpFlags),
    .enables(enReg)
  );

  pcint_control #(
    .NUM_GROUPS(NUM_GROUPS),
    .VEC_W     (VEC_W),
    .VEC_BASE  (VEC_BASE),
    .VEC_STEP  (VEC_STEP),
    .ENTRY_CYC (ENTRY_CYC)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .flags  (grpFlags),
    .enables(enReg),
    .intAck (intAck),
    .irq    (irq),
    .vector (vector),
    .strobe (strobe)
  );
endmodule

// File: rtl/pcint_unit_chk.sv
module pcint_unit_chk #(
  parameter int NUM_GROUPS = 3,
  parameter int GRP_PINS   = 8,
  parameter int VEC_W      = 8,
  parameter int VEC_BASE   = 6,
  parameter int VEC_STEP   = 2
) (
  input logic                           clk,
  input logic                           rstN,
  input logic [NUM_GROUPS*GRP_PINS-1:0] pinBus,
  input logic [NUM_GROUPS-1:0]          grpFlags,
  input logic [NUM_GROUPS-1:0]          enReg,
  input logic                           intAck,
  input logic                           irq,
  input logic [VEC_W-1:0]               vector
);
  // R6: a request needs a pending group that is enabled
  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((grpFlags & enReg) != '0));

  // R7: presented vector is one of the group vectors
  a_r7_vector_legal: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((int'(vector) >= VEC_BASE) &&
             (int'(vector) < VEC_BASE + NUM_GROUPS * VEC_STEP) &&
             (((int'(vector) - VEC_BASE) % VEC_STEP) == 0)));

  // R8: accepted acknowledge silences the request for the entry window
  a_r8_entry_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && irq) |=> !irq ##1 !irq);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gChk
    // R2: a pending bit only rises after its group's pins moved
    a_r2_flag_needs_edge: assert property (@(posedge clk) disable iff (!rstN)
      $rose(grpFlags[g]) |->
        ($past(pinBus[g*GRP_PINS +: GRP_PINS]) != $past(pinBus[g*GRP_PINS +: GRP_PINS], 2)));
  end
endmodule

bind pcint_unit pcint_unit_chk #(
  .NUM_GROUPS(NUM_GROUPS),
  .GRP_PINS  (GRP_PINS),
  .VEC_W     (VEC_W),
  .VEC_BASE  (VEC_BASE),
  .VEC_STEP  (VEC_STEP)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .pinBus  (pinBus),
  .grpFlags(grpFlags),
  .enReg   (enReg),
  .intAck  (intAck),
  .irq     (irq),
  .vector  (vector)
);

// File: tb/sim_pcint_unit.sv
module sim_pcint_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] pinBus = '0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        intAck = 1'b0;
  logic        irq;
  logic [7:0]  vector;
  logic [2:0]  grpFlags;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pcint_unit u0 (
    .clk(clk), .rstN(rstN), .pinBus(pinBus), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .intAck(intAck), .irq(irq), .vector(vector), .grpFlags(grpFlags)
  );

  // {pin levels, expected pending bits}; masks g0=08, g1=F0, g2=01, enables off
  localparam logic [26:0] STEPS [8] = '{
    {24'h000000, 3'b000},  // R4: no change at all
    {24'h000008, 3'b001},  // R2: g0 pin3 rises
    {24'h000000, 3'b001},  // R3: g0 pin3 falls
    {24'h000004, 3'b000},  // R4: g0 pin2 unmasked
    {24'h002004, 3'b010},  // R2: g1 pin5 rises
    {24'h012104, 3'b100},  // R2/R4: g2 pin0 masked, g1 pin0 unmasked
    {24'h000108, 3'b111},  // R3: mixed rise/fall across groups
    {24'h000108, 3'b000}   // R4: steady pins
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ack();
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flags in reset", 32'(grpFlags), 0);
    check("R1 irq in reset", 32'(irq), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 flags after reset", 32'(grpFlags), 0);

    wr(3'd0, 8'h08);
    wr(3'd1, 8'hF0);
    wr(3'd2, 8'h01);

    for (int i = 0; i < 8; i++) begin
      pinBus = STEPS[i][26:3];
      @(negedge clk);
      check($sformatf("R2/R3/R4 table step %0d", i), 32'(grpFlags), 32'(STEPS[i][2:0]));
      wr(3'd4, 8'h07);
    end

    // R4: pin high before its mask bit is set
    pinBus = 24'h00010A;
    @(negedge clk);
    check("R4 unmasked rise", 32'(grpFlags), 0);
    wr(3'd0, 8'h0A);
    @(negedge clk);
    check("R4 high before mask", 32'(grpFlags), 0);
    pinBus = 24'h000108;
    @(negedge clk);
    check("R4 later fall sets", 32'(grpFlags), 1);
    wr(3'd4, 8'h07);

    // R5: partial clear
    pinBus = 24'h002100;
    @(negedge clk);
    check("R5 two pending", 32'(grpFlags), 3);
    wr(3'd4, 8'h01);
    check("R5 partial clear", 32'(grpFlags), 2);
    wr(3'd4, 8'h07);
    check("R5 full clear", 32'(grpFlags), 0);

    // R6: enable gating
    pinBus = 24'h012100;
    @(negedge clk);
    check("R6 flag while disabled", 32'(grpFlags), 4);
    check("R6 no irq while disabled", 32'(irq), 0);
    wr(3'd3, 8'h04);
    check("R6 irq once enabled", 32'(irq), 1);
    check("R7 vector group2", 32'(vector), 10);
    wr(3'd4, 8'h07);
    check("R6 irq after clear", 32'(irq), 0);

    // R9: acknowledge with no request
    pinBus = 24'h012108;
    @(negedge clk);
    check("R9 pending but disabled", 32'(irq), 0);
    ack();
    check("R9 ack ignored", 32'(grpFlags), 1);
    wr(3'd4, 8'h07);

    // R7/R8: priority and entry window
    wr(3'd3, 8'h07);
    pinBus = 24'h000100;
    @(negedge clk);
    check("R7 all pending", 32'(grpFlags), 7);
    check("R7 vector lowest", 32'(vector), 6);
    check("R7 irq", 32'(irq), 1);
    ack();
    check("R8 only group0 cleared", 32'(grpFlags), 6);
    check("R8 entry cycle 1", 32'(irq), 0);
    @(negedge clk);
    check("R8 entry cycle 2", 32'(irq), 0);
    @(negedge clk);
    check("R8 irq back", 32'(irq), 1);
    check("R7 vector group1", 32'(vector), 8);
    ack();
    check("R8 group1 cleared", 32'(grpFlags), 4);
    repeat (2) @(negedge clk);
    check("R7 vector group2 next", 32'(vector), 10);
    ack();
    check("R8 group2 cleared", 32'(grpFlags), 0);
    repeat (2) @(negedge clk);

    // R10: change and clear in the same cycle
    pinBus = 24'h000108;
    wr(3'd4, 8'h07);
    check("R10 set wins", 32'(grpFlags), 1);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    finished = 1;
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule